// File: doc/BRIEF.md
# Wait-Stated Bank Decoder for a Byte-Wide Peripheral

This block connects a processor's wide external port to slow byte-wide devices. The external address space above a fixed base is cut into four banks of equal size, placed one after another. Each bank has its own active-low select line. When an access lands in a bank, the block first presents the low address bits to the device. It then pulls that bank's select and the read or write strobe low. The strobe stays low for a wait-state count that the block keeps for that bank, because the device returns no acknowledge.

The byte moves on one fixed lane of the wide data word, bits 23 to 16. Writes take that lane from the processor word. Reads return the device byte on that lane with every other bit zero. A small register-write port sets the bank size and the wait count of each bank. When the bank size changes, the base addresses of banks 1 to 3 move with it.

Top module: `ext_bank_decoder`

## Requirements
- R1: After reset, all four selects, `ext_rd_n` and `ext_wr_n` are high, and `ext_dout_oe` and `cpu_ack` are low. The bank size code is 0 and every bank's wait count is 15.
- R2: With size code c, the bank size is S = 8192·2^c words. Bank i covers 0x00400000 + i·S up to 0x00400000 + (i+1)·S − 1. During an access, only the select `ext_sel_n[i]` of the addressed bank goes low.
- R3: A request whose address is below 0x00400000, or at or above 0x00400000 + 4·S, drives no select and gives no acknowledge.
- R4: A configuration write to address 0 loads the size code from `cfg_wdata[3:0]`. The new size applies to later accesses.
- R5: A configuration write to address 1+i loads the wait count W of bank i from `cfg_wdata[3:0]`. The strobe of that bank then stays low for exactly W+1 cycles.
- R6: A request is sampled at a rising edge. The block spends one address-only cycle. The select and the strobe then go low together, one edge later. `cpu_ack` pulses high for one cycle, right after the strobe rises. Measured from the sampling edge, the acknowledge therefore appears after W+2 further edges.
- R7: `ext_addr` carries `cpu_addr[3:0]` of the access. It holds that value for the whole time the select is low.
- R8: On a write, `ext_wr_n` is the strobe and `ext_rd_n` stays high. `ext_dout` carries `cpu_wdata[23:16]`, and `ext_dout_oe` is high in exactly the cycles in which `ext_wr_n` is low.
- R9: On a read, `ext_rd_n` is the strobe and `ext_wr_n` stays high. While `cpu_ack` is high, `cpu_rdata[23:16]` holds `ext_din` as sampled in the last strobe cycle, and all other bits are 0. After a write, `cpu_rdata` is 0.
- R10: A request that arrives while an access is in progress is ignored. It gives no acknowledge and no select.
- R11: Configuration writes to addresses 5 to 7 change no setting.
- R12: A reset during an access returns every bus output to the idle levels of R1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register address (0 size, 1..4 bank wait) |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_req | input | 1 | Access request, sampled at the rising edge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word address of the access |
| cpu_wdata | input | 32 | Wide write data; the byte is on bits 23:16 |
| cpu_rdata | output | 32 | Read data; byte on bits 23:16, other bits zero |
| cpu_ack | output | 1 | One-cycle completion pulse |
| ext_sel_n | output | 4 | Active-low bank selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_addr | output | 4 | Device register address |
| ext_dout | output | 8 | Byte driven toward the device |
| ext_dout_oe | output | 1 | Output enable for `ext_dout` |
| ext_din | input | 8 | Byte returned by the device |

## Verification
The hardest cases to reach are those where the block must act on a mapping or timing it holds internally. One is a bank boundary that has moved because the size code was rewritten. The bench rewrites the code and then reaches the same physical addresses again, this time landing in different banks. Another is a second request that arrives in the middle of a long wait sequence. The bench first programs a slow bank, then pulses a request into the strobe window and counts acknowledges. A reset in the middle of a strobe is forced the same way.

// File: rtl/ebd_pkg.sv
package ebd_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_SETUP  = 2'd1,
    ACC_STROBE = 2'd2
  } acc_state_e;

endpackage

// File: rtl/ebd_cfg_regs.sv
module ebd_cfg_regs #(
  parameter int NUM_BANKS   = 4,
  parameter int SIZE_CODE_W = 4,
  parameter int WAIT_W      = 4,
  parameter int CFG_DW      = 8,
  parameter int CFG_AW      = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [CFG_DW-1:0]                   cfg_wdata,
  output logic [SIZE_CODE_W-1:0]              size_code,
  output logic [NUM_BANKS-1:0][WAIT_W-1:0]    wait_cnt
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_code <= '0;
    end else if (cfg_we && cfg_addr == '0) begin
      size_code <= cfg_wdata[SIZE_CODE_W-1:0];
    end
  end

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_wait
    logic [WAIT_W-1:0] wq;
    always_ff @(posedge clk) begin
      if (rst) begin
        wq <= '1;
      end else if (cfg_we && cfg_addr == CFG_AW'(gi + 1)) begin
        wq <= cfg_wdata[WAIT_W-1:0];
      end
    end
    assign wait_cnt[gi] = wq;
  end

endmodule

// File: rtl/ebd_addr_decode.sv
module ebd_addr_decode #(
  parameter int          ADDR_W       = 32,
  parameter int unsigned BANK_BASE    = 32'h0040_0000,
  parameter int          NUM_BANKS    = 4,
  parameter int          MIN_SIZE_LOG = 13,
  parameter int          SIZE_CODE_W  = 4,
  parameter int          BANK_W       = 2
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SIZE_CODE_W-1:0] size_code,
  output logic                   hit,
  output logic [BANK_W-1:0]      bank
);

  localparam int SH_W = $clog2(ADDR_W) + 1;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] index;
  logic [SH_W-1:0]   shamt;
  logic              below;

  always_comb begin
    below  = addr < ADDR_W'(BANK_BASE);
    offset = addr - ADDR_W'(BANK_BASE);
    shamt  = SH_W'(MIN_SIZE_LOG) + SH_W'(size_code);
    index  = offset >> shamt;
    hit    = !below && (index < ADDR_W'(NUM_BANKS));
    bank   = index[BANK_W-1:0];
  end

endmodule

// File: rtl/ebd_lane_steer.sv
module ebd_lane_steer #(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int LANE_LSB = 16
) (
  input  logic [DATA_W-1:0] wide_wdata,
  output logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [DATA_W-1:0] wide_rdata
);

  logic unused_wide_bits;
  assign unused_wide_bits = ^wide_wdata;

  assign wr_byte = wide_wdata[LANE_LSB +: BYTE_W];

  for (genvar gb = 0; gb < DATA_W; gb++) begin : g_bit
    if (gb >= LANE_LSB && gb < LANE_LSB + BYTE_W) begin : g_lane
      assign wide_rdata[gb] = rd_byte[gb - LANE_LSB];
    end else begin : g_zero
      assign wide_rdata[gb] = 1'b0;
    end
  end

endmodule

// File: rtl/ebd_access_seq.sv
module ebd_access_seq
  import ebd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int WAIT_W    = 4,
  parameter int PADDR_W   = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             start_we,
  input  logic [BANK_W-1:0]                start_bank,
  input  logic [PADDR_W-1:0]               start_paddr,
  input  logic [BYTE_W-1:0]                start_wbyte,
  input  logic [NUM_BANKS-1:0][WAIT_W-1:0] wait_cnt,
  input  logic [BYTE_W-1:0]                ext_din,
  output logic                             busy,
  output logic [NUM_BANKS-1:0]             sel_n,
  output logic                             rd_n,
  output logic                             wr_n,
  output logic                             dout_oe,
  output logic [BYTE_W-1:0]                dout,
  output logic [PADDR_W-1:0]               paddr,
  output logic                             done,
  output logic [BYTE_W-1:0]                rd_byte
);

  acc_state_e          state;
  logic [BANK_W-1:0]   bank_q;
  logic                we_q;
  logic [WAIT_W-1:0]   cnt;

  assign busy = state != ACC_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ACC_IDLE;
      bank_q  <= '0;
      we_q    <= 1'b0;
      cnt     <= '0;
      sel_n   <= '1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      dout_oe <= 1'b0;
      dout    <= '0;
      paddr   <= '0;
      done    <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ACC_IDLE: begin
          if (start) begin
            bank_q <= start_bank;
            we_q   <= start_we;
            paddr  <= start_paddr;
            dout   <= start_wbyte;
            state  <= ACC_SETUP;
          end
        end
        ACC_SETUP: begin
          sel_n   <= ~(NUM_BANKS'(1) << bank_q);
          rd_n    <= we_q;
          wr_n    <= !we_q;
          dout_oe <= we_q;
          cnt     <= wait_cnt[bank_q];
          state   <= ACC_STROBE;
        end
        ACC_STROBE: begin
          if (cnt == '0) begin
            sel_n   <= '1;
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            dout_oe <= 1'b0;
            done    <= 1'b1;
            rd_byte <= we_q ? '0 : ext_din;
            state   <= ACC_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ext_bank_decoder.sv
module ext_bank_decoder #(
  parameter int          ADDR_W       = 32,
  parameter int          DATA_W       = 32,
  parameter int          BYTE_W       = 8,
  parameter int          LANE_LSB     = 16,
  parameter int          NUM_BANKS    = 4,
  parameter int unsigned BANK_BASE    = 32'h0040_0000,
  parameter int          MIN_SIZE_LOG = 13,
  parameter int          SIZE_CODE_W  = 4,
  parameter int          WAIT_W       = 4,
  parameter int          PADDR_W      = 4,
  parameter int          CFG_DW       = 8,
  parameter int          CFG_AW       = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_ack,
  output logic [NUM_BANKS-1:0] ext_sel_n,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n,
  output logic [PADDR_W-1:0]   ext_addr,
  output logic [BYTE_W-1:0]    ext_dout,
  output logic                 ext_dout_oe,
  input  logic [BYTE_W-1:0]    ext_din
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [SIZE_CODE_W-1:0]           size_code;
  logic [NUM_BANKS-1:0][WAIT_W-1:0] wait_cnt;
  logic                             hit;
  logic [BANK_W-1:0]                bank;
  logic                             busy;
  logic                             start;
  logic [BYTE_W-1:0]                wr_byte;
  logic [BYTE_W-1:0]                rd_byte;

  ebd_cfg_regs #(
    .NUM_BANKS(NUM_BANKS), .SIZE_CODE_W(SIZE_CODE_W), .WAIT_W(WAIT_W),
    .CFG_DW(CFG_DW), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .size_code(size_code), .wait_cnt(wait_cnt)
  );

  ebd_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .NUM_BANKS(NUM_BANKS),
    .MIN_SIZE_LOG(MIN_SIZE_LOG), .SIZE_CODE_W(SIZE_CODE_W), .BANK_W(BANK_W)
  ) u_dec (
    .addr(cpu_addr), .size_code(size_code), .hit(hit), .bank(bank)
  );

  ebd_lane_steer #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANE_LSB(LANE_LSB)
  ) u_lane (
    .wide_wdata(cpu_wdata), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .wide_rdata(cpu_rdata)
  );

  assign start = cpu_req && hit && !busy;

  ebd_access_seq #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .WAIT_W(WAIT_W),
    .PADDR_W(PADDR_W), .BYTE_W(BYTE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_we(cpu_we),
    .start_bank(bank), .start_paddr(cpu_addr[PADDR_W-1:0]),
    .start_wbyte(wr_byte), .wait_cnt(wait_cnt), .ext_din(ext_din),
    .busy(busy), .sel_n(ext_sel_n), .rd_n(ext_rd_n), .wr_n(ext_wr_n),
    .dout_oe(ext_dout_oe), .dout(ext_dout), .paddr(ext_addr),
    .done(cpu_ack), .rd_byte(rd_byte)
  );

endmodule

// File: rtl/ebd_bus_checker.sv
module ebd_bus_checker #(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int LANE_LSB  = 16,
  parameter int NUM_BANKS = 4,
  parameter int WAIT_W    = 4,
  parameter int PADDR_W   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_W-1:0]    cpu_rdata,
  input logic                 cpu_ack,
  input logic [NUM_BANKS-1:0] ext_sel_n,
  input logic                 ext_rd_n,
  input logic                 ext_wr_n,
  input logic [PADDR_W-1:0]   ext_addr,
  input logic                 ext_dout_oe
);

  localparam logic [DATA_W-1:0] LANE_MASK = DATA_W'({BYTE_W{1'b1}}) << LANE_LSB;
  localparam int               RUN_W     = WAIT_W + 2;

  logic any_sel;
  logic strobe;
  logic [RUN_W-1:0] run;

  assign any_sel = ext_sel_n != '1;
  assign strobe  = !ext_rd_n || !ext_wr_n;

  always_ff @(posedge clk) begin
    if (rst)         run <= '0;
    else if (strobe) run <= run + 1'b1;
    else             run <= '0;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_sel_n)); // R2
  AST_STROBE_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
    strobe |-> any_sel); // R6
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> ($past(strobe) && !strobe)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n)); // R8
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    ext_dout_oe == !ext_wr_n); // R8
  AST_PADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (any_sel && $past(any_sel)) |-> $stable(ext_addr)); // R7
  AST_RDATA_LANE_ONLY: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> ((cpu_rdata & ~LANE_MASK) == '0)); // R9
  AST_STROBE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_W'(1 << WAIT_W)); // R5

endmodule

bind ext_bank_decoder ebd_bus_checker #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANE_LSB(LANE_LSB),
  .NUM_BANKS(NUM_BANKS), .WAIT_W(WAIT_W), .PADDR_W(PADDR_W)
) u_bus_chk (
  .clk(clk), .rst(rst), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
  .ext_sel_n(ext_sel_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
  .ext_addr(ext_addr), .ext_dout_oe(ext_dout_oe)
);

// File: tb/ext_bank_decoder_test.sv
module ext_bank_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack;
  logic [3:0]  ext_sel_n;
  logic        ext_rd_n;
  logic        ext_wr_n;
  logic [3:0]  ext_addr;
  logic [7:0]  ext_dout;
  logic        ext_dout_oe;
  logic [7:0]  ext_din = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  ext_bank_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .ext_sel_n(ext_sel_n), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_addr(ext_addr), .ext_dout(ext_dout),
    .ext_dout_oe(ext_dout_oe), .ext_din(ext_din)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access and observes the bus at falling edges.
  task automatic do_access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                           input logic [7:0] pin, output int lat, output int strobes,
                           output logic [3:0] selseen, output logic [3:0] pa,
                           output logic [7:0] dseen, output logic [31:0] rd,
                           output bit oe_ok, output bit wrong);
    lat = 0; strobes = 0; selseen = '0; pa = '0; dseen = '0; rd = '0;
    oe_ok = 1'b1; wrong = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; ext_din = pin;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      if (ext_sel_n != 4'hF) begin
        selseen = selseen | ~ext_sel_n;
        pa = ext_addr;
        if (we ? !ext_wr_n : !ext_rd_n) strobes++;
        if (we ? !ext_rd_n : !ext_wr_n) wrong = 1'b1;
        if (we && ext_dout_oe) dseen = ext_dout;
      end
      if (ext_dout_oe != !ext_wr_n) oe_ok = 1'b0;
      if (cpu_ack) begin
        lat = k; rd = cpu_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [7:0]  pin;
    logic [1:0]  bank;
    logic [3:0]  wt;
    logic [3:0]  pa;
    logic [7:0]  byte_exp;
  } vec_t;

  // Size code 0 (8K words); waits: bank0=2 bank1=0 bank2=3 bank3=6
  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0040_0005, 32'h0,         8'h3C, 2'd0, 4'd2, 4'h5, 8'h3C},
    '{1'b1, 32'h0040_2000, 32'hAB12_CD34, 8'h00, 2'd1, 4'd0, 4'h0, 8'h12},
    '{1'b0, 32'h0040_4FFF, 32'h0,         8'hE7, 2'd2, 4'd3, 4'hF, 8'hE7},
    '{1'b1, 32'h0040_6003, 32'h00A5_0000, 8'h00, 2'd3, 4'd6, 4'h3, 8'hA5},
    '{1'b0, 32'h0040_7FFF, 32'h0,         8'h81, 2'd3, 4'd6, 4'hF, 8'h81},
    '{1'b0, 32'h0040_1FFE, 32'h0,         8'h5A, 2'd0, 4'd2, 4'hE, 8'h5A}
  };

  initial begin
    int lat, st;
    logic [3:0] sel, pa;
    logic [7:0] dseen;
    logic [31:0] rd;
    bit oe_ok, wrong;
    int acks;
    logic [3:0] selacc;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(ext_sel_n == 4'hF, "R1 selects idle in reset", 32'(ext_sel_n), 32'hF);
    check(ext_rd_n && ext_wr_n, "R1 strobes idle in reset", {30'b0, ext_rd_n, ext_wr_n}, 32'h3);
    check(!ext_dout_oe && !cpu_ack, "R1 oe and ack low", {30'b0, ext_dout_oe, cpu_ack}, 32'h0);
    rst = 1'b0;

    // R1 default waits 15 and size code 0: 0x00406000 is bank 3
    do_access(1'b0, 32'h0040_6000, 32'h0, 8'h11, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(sel == 4'b1000, "R1 default size maps to bank3", 32'(sel), 32'h8);
    check(st == 16, "R1 default wait 15 strobe cycles", 32'(st), 32'd16);

    cfg_write(3'd1, 8'h02);
    cfg_write(3'd2, 8'h00);
    cfg_write(3'd3, 8'h03);
    cfg_write(3'd4, 8'hF6); // R5: upper bits of data ignored -> 6

    for (int v = 0; v < 6; v++) begin
      do_access(VECS[v].we, VECS[v].addr, VECS[v].wdata, VECS[v].pin,
                lat, st, sel, pa, dseen, rd, oe_ok, wrong);
      check(sel == (4'b1 << VECS[v].bank), "R2 bank select", 32'(sel), 32'(4'b1 << VECS[v].bank));
      check(st == VECS[v].wt + 1, "R5 strobe width", 32'(st), 32'(VECS[v].wt + 1));
      check(lat == VECS[v].wt + 3, "R6 ack latency", 32'(lat), 32'(VECS[v].wt + 3));
      check(pa == VECS[v].pa, "R7 device register address", 32'(pa), 32'(VECS[v].pa));
      check(!wrong, "R8 R9 only matching strobe used", 32'(wrong), 32'h0);
      check(oe_ok, "R8 output enable follows write strobe", 32'(oe_ok), 32'h1);
      if (VECS[v].we) begin
        check(dseen == VECS[v].byte_exp, "R8 write lane byte", 32'(dseen), 32'(VECS[v].byte_exp));
        check(rd == 32'h0, "R9 rdata zero after write", rd, 32'h0);
      end else begin
        check(rd == {8'h0, VECS[v].byte_exp, 16'h0}, "R9 read lane data", rd, {8'h0, VECS[v].byte_exp, 16'h0});
      end
    end

    // R3 misses at size code 0
    do_access(1'b0, 32'h003F_FFFF, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(lat == 0 && sel == 0, "R3 below base ignored", 32'(lat), 32'h0);
    do_access(1'b1, 32'h0040_8000, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(lat == 0 && sel == 0, "R3 above bank3 ignored", 32'(sel), 32'h0);

    // R4 size code 1: 16K words per bank
    cfg_write(3'd0, 8'h01);
    do_access(1'b0, 32'h0040_6000, 32'h0, 8'h42, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(sel == 4'b0010, "R4 0x406000 moves to bank1", 32'(sel), 32'h2);
    do_access(1'b0, 32'h0040_C001, 32'h0, 8'h42, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(sel == 4'b1000, "R4 0x40C001 in bank3", 32'(sel), 32'h8);
    check(pa == 4'h1, "R7 address bits at size 1", 32'(pa), 32'h1);
    do_access(1'b0, 32'h0041_0000, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(lat == 0 && sel == 0, "R3 end of enlarged range", 32'(lat), 32'h0);
    do_access(1'b0, 32'h0040_8000, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(sel == 4'b0100, "R4 0x408000 now bank2", 32'(sel), 32'h4);

    // R11 writes to unused config addresses change nothing
    cfg_write(3'd5, 8'h00);
    cfg_write(3'd6, 8'h00);
    cfg_write(3'd7, 8'h00);
    do_access(1'b0, 32'h0040_C000, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(st == 7, "R11 bank3 wait unchanged", 32'(st), 32'd7);
    check(sel == 4'b1000, "R11 size unchanged", 32'(sel), 32'h8);

    // R5 rewrite bank0 wait to 0
    cfg_write(3'd1, 8'h00);
    do_access(1'b0, 32'h0040_0000, 32'h0, 8'h77, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(st == 1, "R5 bank0 wait zero", 32'(st), 32'd1);

    // R10 request during an access is ignored
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h0040_C000;
    @(negedge clk);
    cpu_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h0040_0002;
    @(negedge clk);
    cpu_req = 1'b0;
    acks = 0; selacc = '0;
    for (int k = 0; k < 25; k++) begin
      if (cpu_ack) acks++;
      selacc = selacc | ~ext_sel_n;
      @(negedge clk);
    end
    check(acks == 1, "R10 one ack only", 32'(acks), 32'd1);
    check(selacc == 4'b1000, "R10 second bank never selected", 32'(selacc), 32'h8);

    // R12 reset during an access
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0040_C000; cpu_wdata = 32'h00FF_0000;
    @(negedge clk);
    cpu_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ext_sel_n == 4'b0111, "R12 access in progress", 32'(ext_sel_n), 32'h7);
    rst = 1'b1;
    @(negedge clk);
    check(ext_sel_n == 4'hF && ext_wr_n && !ext_dout_oe, "R12 idle after reset",
          {27'b0, ext_sel_n, ext_wr_n}, 32'h1F);
    rst = 1'b0;
    do_access(1'b0, 32'h0040_6000, 32'h0, 8'h00, lat, st, sel, pa, dseen, rd, oe_ok, wrong);
    check(sel == 4'b1000 && st == 16, "R12 config back to defaults", 32'(st), 32'd16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule